// File: doc/BRIEF.md
# DMA Transfer Termination Controller

This block is a small dual-address DMA engine with a parameterised number of channels. The default is three channels, and two to four are allowed. Each channel moves data one unit at a time. A unit is a read from the channel's source address followed by a write of the read data to its destination address, over a request/acknowledge memory bus. The design is mainly about how transfers end. Normal completion, when a channel's count runs out, is the only event that raises the channel's end flag. That flag can in turn raise an interrupt request.

The other stop conditions halt transfers without raising any end flag:
- software clearing a channel's enable bit;
- software clearing the global master enable;
- an NMI edge;
- a misaligned address.

A global stop that arrives during a unit never cuts that unit short. The write still happens and the channel's registers advance, and the engine then drops bus ownership. Software sets up channels and reads status through a single-cycle write port and a combinational read port.

Top module: `dmat_top`

## Requirements
- R1: When a unit completes on a channel whose count was 1, the count becomes 0, the channel's done flag (control bit 2) is set, and that channel issues no further bus requests.
- R2: `irq` is high exactly when some channel has both its done flag and its interrupt-enable bit (control bit 1) set. Writing a control word with bit 2 at 0 clears the done flag, and writing 1 there has no effect.
- R3: Writing a channel's enable bit (control bit 0) to 0 stops that channel once any unit in progress has finished. Its count stays at the remaining value and its done flag stays 0.
- R4: A rising edge on `nmi_in` sets the NMI flag (global bit 1). This stops all channels without setting any done flag. Writing global bit 1 as 0 clears the flag and transfers resume. Writing 1 there has no effect.
- R5: If the highest-priority ready channel has a source or destination address that is not a multiple of its unit size, the address-error flag (global bit 2) is set and no bus request is made. All channels stay stopped until software writes global bit 2 as 0.
- R6: Writing the master enable (global bit 0) to 0 stops all channels after the unit in progress, without setting any done flag. No unit starts while it is 0.
- R7: A global or channel stop raised during a unit's read phase still lets that unit's write happen with the read data. The source, destination and count registers then advance exactly once.
- R8: `bus_own` is high only from the start of a unit until its write is acknowledged. It is low whenever the engine is halted or idle.
- R9: Channels are arbitrated once per unit with fixed priority. Channel 0 is highest.
- R10: Each unit reads from the source address, then writes the read data to the destination address, holding each request and address until acknowledged. The count then decrements by 1, and both addresses advance by the unit size. The size is set in control bits 4:3 (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).
- R11: Register map:
  - Channel c uses addresses 4c+0 (source), 4c+1 (destination), 4c+2 (count) and 4c+3 (control).
  - The global register is at address 16.
  - All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| nmi_in | input | 1 | Non-maskable interrupt line, edge sensitive |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | 32 | Memory read data |
| bus_own | output | 1 | Engine holds the memory bus |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
The bench raises an NMI, clears a channel enable, and clears the master enable, each in the exact cycle where a unit sits in its read phase. A design that aborted at once would show a missing write and an unchanged count. A design that ignored the stop would run on past one extra unit. After every abort it checks that the done flag and the interrupt stay low, since a design that merged abort with completion would raise them. A misaligned source checks that the address-error flag is set with no write on the bus. Two simultaneously ready channels check that channel 0's units all come first.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    parameter int ADDR_W = 16;
    parameter int CNT_W  = 16;
    parameter int DATA_W = 32;
    parameter int RA_W   = 5;

    localparam logic [RA_W-1:0] GLB_ADDR = RA_W'(16);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } unit_sz_e;

    typedef struct packed {
        unit_sz_e size;
        logic     done;
        logic     ie;
        logic     en;
    } ch_ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        ch_ctrl_t          ctrl;
    } ch_regs_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_e;

    function automatic logic [ADDR_W-1:0] unit_bytes(unit_sz_e s);
        case (s)
            SZ_BYTE: return ADDR_W'(1);
            SZ_HALF: return ADDR_W'(2);
            default: return ADDR_W'(4);
        endcase
    endfunction

    function automatic logic misaligned(logic [ADDR_W-1:0] a, unit_sz_e s);
        return (a & (unit_bytes(s) - ADDR_W'(1))) != '0;
    endfunction

endpackage

// File: rtl/dmat_chan.sv
module dmat_chan
    import dmat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              unit_done,
    output ch_regs_t          regs,
    output logic              ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    2'd0: regs.src <= wr_data;
                    2'd1: regs.dst <= wr_data;
                    2'd2: regs.cnt <= wr_data[CNT_W-1:0];
                    default: begin
                        regs.ctrl.en   <= wr_data[0];
                        regs.ctrl.ie   <= wr_data[1];
                        regs.ctrl.size <= unit_sz_e'(wr_data[4:3]);
                        if (!wr_data[2]) regs.ctrl.done <= 1'b0;
                    end
                endcase
            end
            if (unit_done) begin
                regs.src <= regs.src + unit_bytes(regs.ctrl.size);
                regs.dst <= regs.dst + unit_bytes(regs.ctrl.size);
                regs.cnt <= regs.cnt - CNT_W'(1);
                if (regs.cnt == CNT_W'(1)) regs.ctrl.done <= 1'b1;
            end
        end
    end

    assign ready = regs.ctrl.en && !regs.ctrl.done && (regs.cnt != '0);

    // R1
    done_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(regs.ctrl.done) |-> $past(unit_done) && ($past(regs.cnt) == CNT_W'(1)));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        unit_done |=> regs.cnt == $past(regs.cnt) - CNT_W'(1));

endmodule

// File: rtl/dmat_arb.sv
module dmat_arb #(
    parameter int N    = 3,
    parameter int CH_W = 2
) (
    input  logic [N-1:0]    req,
    output logic            any,
    output logic [CH_W-1:0] grant
);

    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) grant = CH_W'(i);
        end
    end

    assign any = |req;

    always_comb begin
        // R9
        if (any) prio_low_chk: assert (req[grant] && ((req & ((N'(1) << grant) - N'(1))) == '0));
    end

endmodule

// File: rtl/dmat_eng.sv
module dmat_eng
    import dmat_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              any,
    input  logic [CH_W-1:0]   grant,
    input  ch_regs_t          regs_arr [NUM_CH],
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_own,
    output logic [NUM_CH-1:0] unit_done,
    output logic              addr_err
);

    eng_state_e        state;
    logic [CH_W-1:0]   cur_ch;
    logic [ADDR_W-1:0] a_src, a_dst;
    logic [DATA_W-1:0] data_q;
    ch_regs_t          sel;
    logic              bad_addr;

    always_comb begin
        sel = regs_arr[0];
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant == CH_W'(i)) sel = regs_arr[i];
        end
    end

    assign bad_addr = misaligned(sel.src, sel.ctrl.size) || misaligned(sel.dst, sel.ctrl.size);
    assign addr_err = (state == ENG_IDLE) && go && any && bad_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            cur_ch <= '0;
            a_src  <= '0;
            a_dst  <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (go && any && !bad_addr) begin
                        cur_ch <= grant;
                        a_src  <= sel.src;
                        a_dst  <= sel.dst;
                        state  <= ENG_READ;
                    end
                end
                ENG_READ: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ENG_WRITE;
                    end
                end
                ENG_WRITE: begin
                    if (mem_ack) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ENG_READ) || (state == ENG_WRITE);
    assign mem_we    = (state == ENG_WRITE);
    assign mem_addr  = (state == ENG_WRITE) ? a_dst : a_src;
    assign mem_wdata = data_q;
    assign bus_own   = (state != ENG_IDLE);

    always_comb begin
        unit_done = '0;
        if (state == ENG_WRITE && mem_ack) unit_done[cur_ch] = 1'b1;
    end

    // R7
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_READ) && mem_ack |=> mem_req && mem_we && (mem_wdata == $past(mem_rdata)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    release_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> !bus_own);

endmodule

// File: rtl/dmat_top.sv
module dmat_top
    import dmat_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              nmi_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_own,
    output logic              irq
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    ch_regs_t          regs_a [NUM_CH];
    logic [NUM_CH-1:0] ready, unit_done;
    logic              any, addr_err, go;
    logic [CH_W-1:0]   grant;
    logic              master, nmi_f, ae_f, nmi_q;
    logic              glb_we;

    assign glb_we = reg_we && (reg_addr == GLB_ADDR);
    assign go     = master && !nmi_f && !ae_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            master <= 1'b0;
            nmi_f  <= 1'b0;
            ae_f   <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (glb_we) master <= reg_wdata[0];
            if (nmi_in && !nmi_q)              nmi_f <= 1'b1;
            else if (glb_we && !reg_wdata[1])  nmi_f <= 1'b0;
            if (addr_err)                      ae_f  <= 1'b1;
            else if (glb_we && !reg_wdata[2])  ae_f  <= 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_we;
        assign ch_we = reg_we && !reg_addr[4] && (reg_addr[3:2] == 2'(c));
        dmat_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ch_we),
            .wr_sel    (reg_addr[1:0]),
            .wr_data   (reg_wdata),
            .unit_done (unit_done[c]),
            .regs      (regs_a[c]),
            .ready     (ready[c])
        );
    end

    dmat_arb #(.N(NUM_CH), .CH_W(CH_W)) u_arb (
        .req   (ready),
        .any   (any),
        .grant (grant)
    );

    dmat_eng #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .any       (any),
        .grant     (grant),
        .regs_arr  (regs_a),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .bus_own   (bus_own),
        .unit_done (unit_done),
        .addr_err  (addr_err)
    );

    always_comb begin
        irq = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            irq = irq | (regs_a[c].ctrl.done & regs_a[c].ctrl.ie);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GLB_ADDR) begin
            reg_rdata = ADDR_W'({ae_f, nmi_f, master});
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (!reg_addr[4] && reg_addr[3:2] == 2'(c)) begin
                    case (reg_addr[1:0])
                        2'd0:    reg_rdata = regs_a[c].src;
                        2'd1:    reg_rdata = regs_a[c].dst;
                        2'd2:    reg_rdata = ADDR_W'(regs_a[c].cnt);
                        default: reg_rdata = ADDR_W'(regs_a[c].ctrl);
                    endcase
                end
            end
        end
    end

    // R4
    nmi_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_f) |-> $past(nmi_in));

    // R5
    ae_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ae_f) |-> !$past(bus_own) && !bus_own);

    // R6
    start_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_own) |-> $past(master) && !$past(nmi_f) && !$past(ae_f));

endmodule

// File: tb/dmat_top_test.sv
`timescale 1ns/1ps
module dmat_top_test;

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  sz;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 2'd0, 16'h0100, 16'h0200, 16'd3},
        '{2'd1, 2'd1, 16'h0300, 16'h0400, 16'd4},
        '{2'd2, 2'd2, 16'h0500, 16'h0600, 16'd2},
        '{2'd0, 2'd3, 16'h1000, 16'h2000, 16'd1}
    };

    logic        clk = 0, rst = 1, reg_we = 0, nmi_in = 0, mem_ack = 0;
    logic [4:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata, mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_req, mem_we, bus_own, irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];
    int          wr_n;

    always #2 clk = ~clk;

    dmat_top uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .bus_own(bus_own), .irq(irq)
    );

    assign mem_rdata = {mem_addr, ~mem_addr};

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wr_n    <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_we && mem_ack) begin
                log_addr[wr_n % 64] <= mem_addr;
                log_data[wr_n % 64] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input int ch);
        logic [15:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(5'(ch * 4 + 3), v);
            if (v[2]) break;
        end
    endtask

    function automatic logic [15:0] bytes_of(input logic [1:0] s);
        return (s == 2'd0) ? 16'd1 : (s == 2'd1) ? 16'd2 : 16'd4;
    endfunction

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
        wr(5'(ch * 4 + 0), s);
        wr(5'(ch * 4 + 1), d);
        wr(5'(ch * 4 + 2), n);
    endtask

    // Waits for a read phase, samples count, returns writes seen so far
    task automatic wait_read(input int ch, output logic [15:0] pre, output int w0);
        reg_addr = 5'(ch * 4 + 2);
        do @(negedge clk); while (!(mem_req && !mem_we));
        #1 pre = reg_rdata;
        w0 = wr_n;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, pre;
        int w0, base;

        repeat (3) @(negedge clk);
        rst = 0;

        // R11 / R8 reset state
        rd(5'd16, v);
        chk(v == 0, "R11 global reset", v, 0);
        rd(5'd3, v);
        chk(v == 0, "R11 ctrl reset", v, 0);
        chk(!irq && !bus_own && !mem_req, "R8 idle after reset", {irq, bus_own, mem_req}, 0);

        wr(5'd16, 16'h0001);

        // Vector table: R1 R2 R10
        for (int k = 0; k < 4; k++) begin
            vec_t t = VECS[k];
            logic [15:0] b = bytes_of(t.sz);
            logic [15:0] ls = t.src + (t.cnt - 1) * b;
            int cb = 4 * int'(t.ch);
            setup(int'(t.ch), t.src, t.dst, t.cnt);
            base = wr_n;
            wr(5'(cb + 3), {11'd0, t.sz, 3'b011});
            wait_done(int'(t.ch));
            @(negedge clk);
            chk(wr_n - base == int'(t.cnt), "R10 unit count", wr_n - base, t.cnt);
            chk(log_addr[(base + int'(t.cnt) - 1) % 64] == t.dst + (t.cnt - 1) * b,
                "R10 last dst addr", log_addr[(base + int'(t.cnt) - 1) % 64], t.dst + (t.cnt - 1) * b);
            chk(log_data[(base + int'(t.cnt) - 1) % 64] == {ls, ~ls},
                "R10 write data", log_data[(base + int'(t.cnt) - 1) % 64], {ls, ~ls});
            rd(5'(cb), v);
            chk(v == t.src + t.cnt * b, "R10 src advance", v, t.src + t.cnt * b);
            rd(5'(cb + 1), v);
            chk(v == t.dst + t.cnt * b, "R10 dst advance", v, t.dst + t.cnt * b);
            rd(5'(cb + 2), v);
            chk(v == 0, "R1 count zero", v, 0);
            chk(irq == 1, "R2 irq on done", irq, 1);
            chk(!bus_own, "R8 released", bus_own, 0);
            wr(5'(cb + 3), 16'h0004);
            rd(5'(cb + 3), v);
            chk(v[2] == 1, "R2 write 1 keeps done", v[2], 1);
            wr(5'(cb + 3), 16'h0000);
            #1 chk(irq == 0, "R2 irq cleared", irq, 0);
        end

        // R4 / R7: NMI during read phase
        setup(0, 16'h0800, 16'h0900, 16'd6);
        wr(5'd3, 16'h0001);
        wait_read(0, pre, w0);
        nmi_in = 1;
        repeat (20) @(negedge clk);
        chk(wr_n == w0 + 1, "R7 write after nmi", wr_n - w0, 1);
        rd(5'd2, v);
        chk(v == pre - 1, "R7 count updated", v, pre - 1);
        rd(5'd0, v);
        chk(v == 16'h0800 + (6 - pre + 1), "R7 src updated", v, 16'h0800 + (6 - pre + 1));
        rd(5'd16, v);
        chk(v[1] == 1, "R4 nmi flag", v, 3);
        rd(5'd3, v);
        chk(v[2] == 0, "R4 no done", v[2], 0);
        chk(!bus_own, "R8 released after nmi", bus_own, 0);
        nmi_in = 0;
        wr(5'd16, 16'h0003);
        rd(5'd16, v);
        chk(v[1] == 1, "R4 write 1 keeps nmi", v, 3);
        wr(5'd16, 16'h0001);
        wait_done(0);
        rd(5'd2, v);
        chk(v == 0, "R4 resumed to end", v, 0);
        chk(irq == 0, "R2 no irq without ie", irq, 1'b0);
        wr(5'd3, 16'h0000);

        // R3 / R7: channel enable cleared during read
        setup(1, 16'h0A00, 16'h0B00, 16'd8);
        wr(5'd7, 16'h0003);
        wait_read(1, pre, w0);
        reg_we = 1; reg_addr = 5'd7; reg_wdata = 16'h0002;
        @(negedge clk);
        reg_we = 0;
        repeat (20) @(negedge clk);
        chk(wr_n == w0 + 1, "R3 unit completed", wr_n - w0, 1);
        rd(5'd6, v);
        chk(v == pre - 1, "R3 count kept", v, pre - 1);
        rd(5'd7, v);
        chk(v[2] == 0 && !irq, "R3 no done", v, 2);
        chk(!bus_own, "R3 idle", bus_own, 0);

        // R6: master cleared during read
        setup(2, 16'h0C00, 16'h0D00, 16'd5);
        wr(5'd11, 16'h0003);
        wait_read(2, pre, w0);
        reg_we = 1; reg_addr = 5'd16; reg_wdata = 16'h0000;
        @(negedge clk);
        reg_we = 0;
        repeat (20) @(negedge clk);
        chk(wr_n == w0 + 1, "R6 unit completed", wr_n - w0, 1);
        rd(5'd10, v);
        chk(v == pre - 1, "R6 count kept", v, pre - 1);
        rd(5'd11, v);
        chk(v[2] == 0 && !irq, "R6 no done", v, 3);
        wr(5'd11, 16'h0000);
        wr(5'd16, 16'h0001);

        // R5: misaligned source
        setup(0, 16'h0002, 16'h0100, 16'd2);
        base = wr_n;
        wr(5'd3, 16'h0011);
        repeat (20) @(negedge clk);
        rd(5'd16, v);
        chk(v[2] == 1, "R5 ae flag", v, 5);
        chk(wr_n == base, "R5 no bus access", wr_n - base, 0);
        rd(5'd2, v);
        chk(v == 2, "R5 count untouched", v, 2);
        wr(5'd0, 16'h0004);
        repeat (10) @(negedge clk);
        chk(wr_n == base, "R5 stays stopped", wr_n - base, 0);
        wr(5'd16, 16'h0001);
        wait_done(0);
        @(negedge clk);
        chk(wr_n == base + 2, "R5 resumes", wr_n - base, 2);
        wr(5'd3, 16'h0000);

        // R9: fixed priority
        wr(5'd16, 16'h0000);
        setup(0, 16'h3000, 16'h3400, 16'd2);
        setup(1, 16'h4000, 16'h4400, 16'd2);
        wr(5'd7, 16'h0001);
        wr(5'd3, 16'h0001);
        base = wr_n;
        wr(5'd16, 16'h0001);
        wait_done(1);
        @(negedge clk);
        chk(log_addr[base % 64] == 16'h3400, "R9 ch0 first", log_addr[base % 64], 16'h3400);
        chk(log_addr[(base + 1) % 64] == 16'h3401, "R9 ch0 second", log_addr[(base + 1) % 64], 16'h3401);
        chk(log_addr[(base + 2) % 64] == 16'h4400, "R9 ch1 after", log_addr[(base + 2) % 64], 16'h4400);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule